// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen architecturally visible 32-bit registers of a small processor core that runs in one of four operating modes: user, fast interrupt, interrupt and supervisor. Some register indices are backed by private physical copies that only exist for a given mode. The fast-interrupt mode keeps its own copies of indices 8 to 14. The interrupt and supervisor modes each keep private copies of indices 13 and 14. Every index that the current mode does not bank falls through to the shared user copy. Software sees one set of sixteen registers, and the hardware picks the physical copy from the mode.

Index 15 is not a storage slot like the others. It is a packed view: a 24-bit program counter sits in bits 25:2 (mask 0x03FFFFFC), six status flags occupy bits 31:26, and the 2-bit mode sits in bits 1:0. The core reads through two combinational ports and writes through one port that commits on the rising clock edge. The mode changes either through a dedicated mode-load input or by writing index 15.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset clears every physical register, the program counter and the flags, and selects supervisor mode (encoding 11). After reset, indices 0 to 14 read 0 and index 15 reads 0x00000003.
- R2: In user mode (encoding 00), indices 0 to 14 read and write the shared user copies.
- R3: In fast-interrupt mode (encoding 01), indices 8 to 14 use private copies. Indices 0 to 7 use the user copies.
- R4: In interrupt mode (encoding 10), indices 13 and 14 use private copies. All other indices use the user copies.
- R5: In supervisor mode (encoding 11), indices 13 and 14 use private copies that are separate from the interrupt-mode copies. All other indices use the user copies.
- R6: When mode_we is high, mode_in becomes the mode at the clock edge. Reads and writes in that same cycle still use the old mode, and the new mapping applies from the next cycle on. mode_out always shows the current mode.
- R7: Any sequence of mode changes, including repeated and back-to-back changes, leaves the contents of every bank unchanged.
- R8: A read of index 15 returns the flags in bits 31:26, the program counter in bits 25:2 and the current mode in bits 1:0.
- R9: A write to index 15 loads the flags and the program counter from the same bit fields. It also loads the mode from bits 1:0, unless mode_we is high in the same cycle, in which case mode_in takes priority.
- R10: The two read ports are independent and combinational: each returns, in the same cycle, the value of its own index under the current mode.
- R11: With wr_en low, wr_idx and wr_data have no effect on any register, the program counter, the flags or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Load mode_in as the new mode at the clock edge |
| mode_in | input | 2 | New mode: 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Visible register index to write |
| wr_data | input | 32 | Write data |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| mode_out | output | 2 | Current mode |

## Verification
Every physical copy is loaded with a value that encodes both its owning bank and its index. A wrong slot selection therefore shows up as a wrong bank nibble or a wrong index byte, not as a quiet match. A walked sequence of modes revisits modes, repeats a mode back-to-back and steps between the two privileged modes that bank only 13 and 14. This sequence separates fast-interrupt overlap from interrupt/supervisor overlap, and catches leakage between the two small banks. Port B reads the indices in reverse order, so the two ports cannot hide a shared selection path. Directed cases cover the following:
- a mode load that coincides with a write, which shows that the write lands in the old bank;
- writes to index 15 with and without a coinciding mode load, which separate the two mode sources;
- disabled writes;
- a reset in the middle of a run.

// File: rtl/brf_pkg.sv
package brf_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_USER = 2'b00,
      MODE_FAST = 2'b01,
      MODE_IRQ  = 2'b10,
      MODE_SUPV = 2'b11
   } brf_mode_e;

endpackage

// File: rtl/brf_slot_map.sv
// Translates a visible register index plus mode into a physical slot number.
module brf_slot_map #(
   parameter int NREG       = 16,
   parameter int FAST_FIRST = 8,
   parameter int PRIV_FIRST = 13
) (
   input  logic [$clog2(NREG)-1:0]              idx,
   input  brf_pkg::brf_mode_e                   mode,
   output logic [$clog2(2*NREG)-1:0]            slot,
   output logic                                 is_status
);
   import brf_pkg::*;

   localparam int IDX_W     = $clog2(NREG);
   localparam int USR_N     = NREG - 1;
   localparam int FAST_N    = USR_N - FAST_FIRST;
   localparam int PRIV_N    = USR_N - PRIV_FIRST;
   localparam int FAST_BASE = USR_N;
   localparam int IRQ_BASE  = FAST_BASE + FAST_N;
   localparam int SUPV_BASE = IRQ_BASE + PRIV_N;
   localparam int SLOT_W    = $clog2(2*NREG);

   assign is_status = (idx == IDX_W'(NREG - 1));

   always_comb begin
      slot = SLOT_W'(idx);
      unique case (mode)
         MODE_FAST: if (idx >= IDX_W'(FAST_FIRST))
                       slot = SLOT_W'(FAST_BASE + int'(idx) - FAST_FIRST);
         MODE_IRQ:  if (idx >= IDX_W'(PRIV_FIRST))
                       slot = SLOT_W'(IRQ_BASE + int'(idx) - PRIV_FIRST);
         MODE_SUPV: if (idx >= IDX_W'(PRIV_FIRST))
                       slot = SLOT_W'(SUPV_BASE + int'(idx) - PRIV_FIRST);
         default:   slot = SLOT_W'(idx);
      endcase
   end

endmodule

// File: rtl/brf_store.sv
// Flat array of physical general-purpose slots, one write port, NRD read ports.
module brf_store #(
   parameter int XLEN   = 32,
   parameter int NPHYS  = 26,
   parameter int SLOT_W = 5,
   parameter int NRD    = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          we,
   input  logic [SLOT_W-1:0]             wslot,
   input  logic [XLEN-1:0]               wdata,
   input  logic [NRD-1:0][SLOT_W-1:0]    rslot,
   output logic [NRD-1:0][XLEN-1:0]      rdata
);

   logic [XLEN-1:0] q [NPHYS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NPHYS; s++) q[s] <= '0;
      end else if (we && (wslot < SLOT_W'(NPHYS))) begin
         q[wslot] <= wdata;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rdata[r] = (rslot[r] < SLOT_W'(NPHYS)) ? q[rslot[r]] : '0;
   end

endmodule

// File: rtl/brf_status.sv
// Program counter, flags and mode, presented as the packed index-15 view.
module brf_status #(
   parameter int XLEN  = 32,
   parameter int PC_LO = 2,
   parameter int PC_HI = 25
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr,
   input  logic [XLEN-1:0]            wdata,
   input  logic                       mode_we,
   input  brf_pkg::brf_mode_e         mode_in,
   output brf_pkg::brf_mode_e         mode_q,
   output logic [XLEN-1:0]            view
);
   import brf_pkg::*;

   localparam int PC_W   = PC_HI - PC_LO + 1;
   localparam int FLAG_W = XLEN - 1 - PC_HI;

   logic [PC_W-1:0]   pc_q;
   logic [FLAG_W-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         flags_q <= '0;
         mode_q  <= MODE_SUPV;
      end else begin
         if (wr) begin
            pc_q    <= wdata[PC_HI:PC_LO];
            flags_q <= wdata[XLEN-1:PC_HI+1];
         end
         if (mode_we)
            mode_q <= mode_in;
         else if (wr)
            mode_q <= brf_mode_e'(wdata[MODE_W-1:0]);
      end
   end

   assign view = {flags_q, pc_q, mode_q};

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
   parameter int XLEN       = 32,
   parameter int NREG       = 16,
   parameter int FAST_FIRST = 8,
   parameter int PRIV_FIRST = 13,
   parameter int PC_LO      = 2,
   parameter int PC_HI      = 25
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     mode_we,
   input  logic [1:0]               mode_in,
   input  logic                     wr_en,
   input  logic [$clog2(NREG)-1:0]  wr_idx,
   input  logic [XLEN-1:0]          wr_data,
   input  logic [$clog2(NREG)-1:0]  rd_a_idx,
   output logic [XLEN-1:0]          rd_a_data,
   input  logic [$clog2(NREG)-1:0]  rd_b_idx,
   output logic [XLEN-1:0]          rd_b_data,
   output logic [1:0]               mode_out
);
   import brf_pkg::*;

   localparam int IDX_W  = $clog2(NREG);
   localparam int USR_N  = NREG - 1;
   localparam int FAST_N = USR_N - FAST_FIRST;
   localparam int PRIV_N = USR_N - PRIV_FIRST;
   localparam int NPHYS  = USR_N + FAST_N + 2 * PRIV_N;
   localparam int SLOT_W = $clog2(2*NREG);
   localparam int NRD    = 2;

   // elaboration-time parameter checks
   if (NREG != (1 << IDX_W))
      $error("NREG must be a power of two");
   if (!(FAST_FIRST > 0 && FAST_FIRST <= PRIV_FIRST && PRIV_FIRST < NREG - 1))
      $error("bank boundaries out of order");
   if (PC_LO != MODE_W)
      $error("program counter field must start right above the mode bits");
   if (!(PC_HI > PC_LO && PC_HI < XLEN - 1))
      $error("program counter field must leave room for flags");
   if (NPHYS > (1 << SLOT_W))
      $error("slot width too narrow");

   brf_mode_e mode_q;
   logic [XLEN-1:0] status_view;

   // write path
   logic [SLOT_W-1:0] w_slot;
   logic              w_is_status;

   brf_slot_map #(.NREG(NREG), .FAST_FIRST(FAST_FIRST), .PRIV_FIRST(PRIV_FIRST)) u_wmap (
      .idx       (wr_idx),
      .mode      (mode_q),
      .slot      (w_slot),
      .is_status (w_is_status)
   );

   brf_status #(.XLEN(XLEN), .PC_LO(PC_LO), .PC_HI(PC_HI)) u_status (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr_en && w_is_status),
      .wdata   (wr_data),
      .mode_we (mode_we),
      .mode_in (brf_mode_e'(mode_in)),
      .mode_q  (mode_q),
      .view    (status_view)
   );

   // read path
   logic [NRD-1:0][IDX_W-1:0]  r_idx;
   logic [NRD-1:0][SLOT_W-1:0] r_slot;
   logic [NRD-1:0]             r_is_status;
   logic [NRD-1:0][XLEN-1:0]   r_store;
   logic [NRD-1:0][XLEN-1:0]   r_data;

   assign r_idx[0] = rd_a_idx;
   assign r_idx[1] = rd_b_idx;

   for (genvar p = 0; p < NRD; p++) begin : g_port
      brf_slot_map #(.NREG(NREG), .FAST_FIRST(FAST_FIRST), .PRIV_FIRST(PRIV_FIRST)) u_rmap (
         .idx       (r_idx[p]),
         .mode      (mode_q),
         .slot      (r_slot[p]),
         .is_status (r_is_status[p])
      );
      assign r_data[p] = r_is_status[p] ? status_view : r_store[p];
   end

   brf_store #(.XLEN(XLEN), .NPHYS(NPHYS), .SLOT_W(SLOT_W), .NRD(NRD)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && !w_is_status),
      .wslot (w_slot),
      .wdata (wr_data),
      .rslot (r_slot),
      .rdata (r_store)
   );

   assign rd_a_data = r_data[0];
   assign rd_b_data = r_data[1];
   assign mode_out  = mode_q;

endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
   parameter int XLEN  = 32,
   parameter int NREG  = 16,
   parameter int PC_LO = 2,
   parameter int PC_HI = 25
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     mode_we,
   input logic [1:0]               mode_in,
   input logic                     wr_en,
   input logic [$clog2(NREG)-1:0]  wr_idx,
   input logic [XLEN-1:0]          wr_data,
   input logic [$clog2(NREG)-1:0]  rd_a_idx,
   input logic [XLEN-1:0]          rd_a_data,
   input logic [$clog2(NREG)-1:0]  rd_b_idx,
   input logic [XLEN-1:0]          rd_b_data,
   input logic [1:0]               mode_out
);
   localparam int IDX_W = $clog2(NREG);
   localparam logic [IDX_W-1:0] ST_IDX = IDX_W'(NREG - 1);

   logic wr_st;
   assign wr_st = wr_en && (wr_idx == ST_IDX);

   p_reset_mode_r1: assert property (@(posedge clk)
      rst |=> (mode_out == 2'b11));

   p_mode_load_r6: assert property (@(posedge clk) disable iff (rst)
      (!rst && mode_we) |=> (mode_out == $past(mode_in)));

   p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!rst && !mode_we && !wr_st) |=> $stable(mode_out));

   p_view_mode_r8: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == ST_IDX) |-> (rd_a_data[1:0] == mode_out));

   p_pc_load_r9: assert property (@(posedge clk) disable iff (rst)
      (!rst && wr_st) |=>
      ((rd_a_idx != ST_IDX) || (rd_a_data[PC_HI:PC_LO] == $past(wr_data[PC_HI:PC_LO]))));

   p_mode_from_data_r9: assert property (@(posedge clk) disable iff (rst)
      (!rst && wr_st && !mode_we) |=> (mode_out == $past(wr_data[1:0])));

   p_ports_agree_r10: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

   p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!rst && !wr_st && rd_a_idx == ST_IDX) |=>
      ((rd_a_idx != ST_IDX) || (rd_a_data[PC_HI:PC_LO] == $past(rd_a_data[PC_HI:PC_LO]))));

endmodule

bind banked_regfile brf_checker #(
   .XLEN(XLEN), .NREG(NREG), .PC_LO(PC_LO), .PC_HI(PC_HI)
) u_brf_chk (
   .clk       (clk),
   .rst       (rst),
   .mode_we   (mode_we),
   .mode_in   (mode_in),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_data   (wr_data),
   .rd_a_idx  (rd_a_idx),
   .rd_a_data (rd_a_data),
   .rd_b_idx  (rd_b_idx),
   .rd_b_data (rd_b_data),
   .mode_out  (mode_out)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

   logic        clk = 1'b0;
   logic        rst;
   logic        mode_we;
   logic [1:0]  mode_in;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic [31:0] wr_data;
   logic [3:0]  rd_a_idx;
   logic [31:0] rd_a_data;
   logic [3:0]  rd_b_idx;
   logic [31:0] rd_b_data;
   logic [1:0]  mode_out;

   always #10 clk = ~clk;   // 50 MHz

   banked_regfile dut (
      .clk(clk), .rst(rst), .mode_we(mode_we), .mode_in(mode_in),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .mode_out(mode_out)
   );

   int checks = 0;
   int errors = 0;

   // walked mode sequence: repeats, back-to-back, privileged pairs
   localparam int SEQ_N = 12;
   localparam logic [1:0] MODE_SEQ [SEQ_N] = '{
      2'b01, 2'b01, 2'b10, 2'b11, 2'b10, 2'b00,
      2'b11, 2'b11, 2'b01, 2'b10, 2'b01, 2'b00 };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(int m, int i);
      return 32'hB000_005A | (32'(m) << 16) | (32'(i) << 8);
   endfunction

   // which bank owns index i in mode m, from R2..R5
   function automatic int owner(int m, int i);
      if (m == 1 && i >= 8) return 1;
      if (m >= 2 && i >= 13) return m;
      return 0;
   endfunction

   function automatic string mode_tag(int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   // all step tasks start and end just after a falling edge
   task automatic step_mode(logic [1:0] m);
      mode_we = 1'b1; mode_in = m;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic step_write(int i, logic [31:0] d);
      wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic verify_all(int m);
      for (int i = 0; i < 15; i++) begin
         rd_a_idx = 4'(i);
         rd_b_idx = 4'(14 - i);
         #1;
         check({mode_tag(m), "/R7 port A"}, rd_a_data, pat(owner(m, i), i));
         check("R10 port B", rd_b_data, pat(owner(m, 14 - i), 14 - i));
      end
      rd_a_idx = 4'd15;
      #1;
      check("R8 view mode bits", 32'(rd_a_data[1:0]), 32'(m));
      check("R6 mode_out", 32'(mode_out), 32'(m));
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      rst = 1'b1; mode_we = 1'b0; mode_in = 2'b00;
      wr_en = 1'b0; wr_idx = '0; wr_data = '0;
      rd_a_idx = '0; rd_b_idx = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      rd_a_idx = 4'd15; #1;
      check("R1 view after reset", rd_a_data, 32'h0000_0003);
      check("R1 mode after reset", 32'(mode_out), 32'h3);
      for (int i = 0; i < 15; i++) begin
         rd_b_idx = 4'(i); #1;
         check("R1 reg cleared", rd_b_data, 32'h0);
      end
      @(negedge clk);

      // fill each bank with its own pattern
      step_mode(2'b00);
      for (int i = 0; i < 15; i++) step_write(i, pat(0, i));
      step_mode(2'b01);
      for (int i = 8; i < 15; i++) step_write(i, pat(1, i));
      step_mode(2'b10);
      for (int i = 13; i < 15; i++) step_write(i, pat(2, i));
      step_mode(2'b11);
      for (int i = 13; i < 15; i++) step_write(i, pat(3, i));

      // R7 table walk over mode sequence
      for (int k = 0; k < SEQ_N; k++) begin
         step_mode(MODE_SEQ[k]);
         verify_all(int'(MODE_SEQ[k]));
      end

      // R6: mode load with a coinciding write; write lands in old (user) bank
      mode_we = 1'b1; mode_in = 2'b01;
      wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'hDEAD_0009;
      rd_a_idx = 4'd9; #1;
      check("R6 read uses old mode same cycle", rd_a_data, pat(0, 9));
      @(negedge clk);
      mode_we = 1'b0; wr_en = 1'b0;
      #1;
      check("R6 new mapping next cycle", rd_a_data, pat(1, 9));
      @(negedge clk);
      step_mode(2'b00);
      rd_a_idx = 4'd9; #1;
      check("R6 write went to old bank", rd_a_data, 32'hDEAD_0009);
      @(negedge clk);

      // R11: disabled write to a general register and to index 15
      wr_en = 1'b0; wr_idx = 4'd5; wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      wr_idx = 4'd15; wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      rd_a_idx = 4'd5; rd_b_idx = 4'd15; #1;
      check("R11 reg unchanged", rd_a_data, pat(0, 5));
      check("R11 view unchanged", rd_b_data, 32'h0000_0000);
      @(negedge clk);

      // R9: index 15 write loads pc, flags and mode
      step_write(15, 32'hA812_3455);
      rd_a_idx = 4'd15; rd_b_idx = 4'd9; #1;
      check("R9 view after write", rd_a_data, 32'hA812_3455);
      check("R9 mode from data", 32'(mode_out), 32'h1);
      check("R9 mapping follows new mode", rd_b_data, pat(1, 9));
      @(negedge clk);

      // R9: mode_we wins over data bits 1:0
      mode_we = 1'b1; mode_in = 2'b10;
      wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h5400_0007;
      @(negedge clk);
      mode_we = 1'b0; wr_en = 1'b0;
      rd_a_idx = 4'd15; #1;
      check("R9 mode_in priority view", rd_a_data, 32'h5400_0006);
      check("R9 mode_in priority mode", 32'(mode_out), 32'h2);
      @(negedge clk);

      // R8: field positions with all pc and flag bits set
      step_write(15, 32'hFFFF_FFFD);
      rd_a_idx = 4'd15; #1;
      check("R8 pc field", rd_a_data & 32'h03FF_FFFC, 32'h03FF_FFFC);
      check("R8 flag field", rd_a_data & 32'hFC00_0000, 32'hFC00_0000);
      check("R8 mode field", rd_a_data & 32'h0000_0003, 32'h0000_0001);
      @(negedge clk);

      // R1: reset in mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      rd_a_idx = 4'd15; rd_b_idx = 4'd13; #1;
      check("R1 view after mid-run reset", rd_a_data, 32'h0000_0003);
      check("R1 banked reg cleared", rd_b_data, 32'h0);
      rd_b_idx = 4'd2; #1;
      check("R1 user reg cleared", rd_b_data, 32'h0);
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule